// File: doc/BRIEF.md
# Level-Sensitive Interrupt Priority Router

This block collects a parameterised set of level-sensitive interrupt lines and steers them to a small number of processor contexts. Each source has a small priority value. Each context has its own enable mask, its own threshold and one request output. A context handles an interrupt in two steps. First it reads its claim register, which returns the ID of the best eligible source and takes that source out of circulation. When service is finished, the context writes that ID back to the same register. This reopens the source, and if the line is still high the source pends again.

Source 0 is reserved and never exists, so a claim value of 0 means nothing was eligible. All registers are reached through one 32-bit register port. The request side is valid/ready. Each accepted request, read or write, produces exactly one response beat on a valid/ready response channel; a write's response carries zero. A response is held, unchanged, until `rsp_ready_i` is high. While it is held, `req_ready_o` stays low, so at most one transaction is outstanding at any time.

Top module: `irq_hub`

## Requirements
- R1: After reset, all priorities, enables and thresholds are zero, nothing is pending, every `irq_o` bit is low, and a claim read returns 0.
- R2: The priority of source N is the word at byte offset 4*N. It holds 3 bits, and the upper bits read as 0. The word at offset 0 (source 0) and words beyond the last source read 0 and ignore writes.
- R3: Context C's enable mask starts at byte 0x2000 + 0x80*C. Source N is bit N%32 of word N/32. Bit 0 of word 0 always reads 0.
- R4: Context C's threshold is at byte 0x200000 + 0x1000*C, and its claim/complete register is at +0x4. The threshold holds 3 bits, and the upper bits read as 0.
- R5: `irq_o[C]` is high exactly when some source is pending, enabled for C, and has a priority strictly above C's threshold. A priority of 0 therefore never raises a request. A line that goes high becomes pending one clock later.
- R6: A claim read returns the eligible source with the highest priority. On a tie, the lowest ID wins. When no source is eligible, the read returns 0.
- R7: A claim read clears the winner's pending state. The winner then cannot pend again, and no context can claim it, until it is completed.
- R8: Writing a claimed source's ID to any claim/complete register completes it. If the line is still high, the source pends again on the following clock; if the line is low, it stays idle.
- R9: A completion write carrying an ID that is out of range, or that is not currently claimed, changes nothing.
- R10: Reads of unmapped offsets return 0, and writes to them change nothing.
- R11: A request is taken when `req_valid_i` and `req_ready_o` are both high. Its response appears on the next clock and stays valid and unchanged until taken. `req_ready_o` is low while a response waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level_i | input | NSRC (indices NSRC:1) | Level interrupt lines; bit N is source N |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request accepted this cycle when high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken this cycle when high |
| rsp_rdata_o | output | 32 | Read data (0 for writes) |
| irq_o | output | NCTX | Per-context interrupt request |

## Verification
A bad gateway state shows in two ways. A source that stays in flight after completion gives a later claim of 0 where the bench expects the ID. A source that is never masked gives the same ID twice; both show on the next claim read, one clock after the request is taken. A wrong winner or a wrong threshold compare shows on `irq_o` in the same cycle that the pending, enable or threshold state changes, and in the data of the next claim response. A faulty response holding register shows as lost or altered data during a back-pressure stall.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam logic [31:0] PRIO_END   = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } region_e;

endpackage

// File: rtl/irq_hub_gateway.sv
module irq_hub_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic inflight_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_o  <= 1'b0;
      inflight_o <= 1'b0;
    end else if (claim_i) begin
      pending_o  <= 1'b0;
      inflight_o <= 1'b1;
    end else begin
      if (level_i && !inflight_o) pending_o <= 1'b1;
      if (complete_i) inflight_o <= 1'b0;
    end
  end

  // R7: only a pending source can be claimed
  a_r7_claim_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |-> pending_o);

  // R7: a claim masks the source
  a_r7_claim_masks: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> (inflight_o && !pending_o));

  // R7: masking persists until a completion
  a_r7_held_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_o && !complete_i) |=> inflight_o);

  // R8: an open gateway with a high line pends
  a_r8_open_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i && !inflight_o && !claim_i) |=> pending_o);

endmodule

// File: rtl/irq_hub_arbiter.sv
module irq_hub_arbiter #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int IDW    = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC:0]                cand_i,
  input  logic [NSRC:0][PRIO_W-1:0]    prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [IDW-1:0]               win_id_o,
  output logic                         req_o
);

  logic [PRIO_W-1:0] best;

  // Ascending scan with a strict compare keeps the lowest ID on ties;
  // starting from the threshold enforces "strictly above".
  always_comb begin
    best     = thr_i;
    win_id_o = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (cand_i[s] && (prio_i[s] > best)) begin
        best     = prio_i[s];
        win_id_o = IDW'(s);
      end
    end
  end

  assign req_o = (win_id_o != '0);

  // R5/R6: a reported winner is a candidate above the threshold
  a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (cand_i[win_id_o] && (prio_i[win_id_o] > thr_i)));

  // R5: no candidates means no request
  a_r5_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_i == '0) |-> !req_o);

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int AW     = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_level_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [31:0]       rsp_rdata_o,
  output logic [NCTX-1:0]   irq_o
);
  import irq_hub_pkg::*;

  localparam int IDW   = $clog2(NSRC + 1);
  localparam int CW    = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int NWORD = (NSRC + 32) / 32;

  logic [NSRC:0][PRIO_W-1:0]             prio_q;
  logic [NCTX-1:0][NSRC:0]               en_q;
  logic [NCTX-1:0][PRIO_W-1:0]           thr_q;
  logic [NSRC:0]                         pend, infl, claim_vec, cmpl_vec;
  logic [NCTX-1:0][IDW-1:0]              win_id;

  region_e      dec_rg;
  logic [CW-1:0] dec_ctx;
  logic [IDW-1:0] dec_src;
  int           dec_word;
  logic [31:0]  a32, off;
  logic [31:0]  rd_data;
  logic         accept, acc_claim, acc_cmpl;

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  // ---------------- address decode ----------------
  always_comb begin
    dec_rg   = RG_NONE;
    dec_ctx  = '0;
    dec_src  = '0;
    dec_word = 0;
    off      = '0;
    a32      = 32'(req_addr_i) & ~32'h3;
    if (a32 < PRIO_END) begin
      if ((32'(a32[11:2]) >= 32'd1) && (32'(a32[11:2]) <= 32'(NSRC))) begin
        dec_rg  = RG_PRIO;
        dec_src = IDW'(a32[11:2]);
      end
    end else if ((a32 >= EN_BASE) && (a32 < EN_BASE + 32'(NCTX) * EN_STRIDE)) begin
      off = a32 - EN_BASE;
      if (32'(off[6:2]) < 32'(NWORD)) begin
        dec_rg   = RG_EN;
        dec_ctx  = CW'(off >> 7);
        dec_word = int'(off[6:2]);
      end
    end else if ((a32 >= CTX_BASE) && (a32 < CTX_BASE + 32'(NCTX) * CTX_STRIDE)) begin
      off     = a32 - CTX_BASE;
      dec_ctx = CW'(off >> 12);
      if (off[11:2] == 10'd0)      dec_rg = RG_THR;
      else if (off[11:2] == 10'd1) dec_rg = RG_CLAIM;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    rd_data = '0;
    unique case (dec_rg)
      RG_PRIO:  rd_data = 32'(prio_q[dec_src]);
      RG_EN: begin
        for (int s = 1; s <= NSRC; s++)
          if ((s / 32) == dec_word) rd_data[s % 32] = en_q[dec_ctx][s];
      end
      RG_THR:   rd_data = 32'(thr_q[dec_ctx]);
      RG_CLAIM: rd_data = 32'(win_id[dec_ctx]);
      default:  rd_data = '0;
    endcase
  end

  // ---------------- claim / complete strobes ----------------
  assign acc_claim = accept && !req_write_i && (dec_rg == RG_CLAIM);
  assign acc_cmpl  = accept &&  req_write_i && (dec_rg == RG_CLAIM);

  always_comb begin
    claim_vec = '0;
    cmpl_vec  = '0;
    for (int s = 1; s <= NSRC; s++) begin
      claim_vec[s] = acc_claim && (win_id[dec_ctx] == IDW'(s));
      cmpl_vec[s]  = acc_cmpl && (req_wdata_i == 32'(s)) && infl[s];
    end
  end

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (accept && req_write_i) begin
      unique case (dec_rg)
        RG_PRIO: prio_q[dec_src] <= req_wdata_i[PRIO_W-1:0];
        RG_EN: begin
          for (int s = 1; s <= NSRC; s++)
            if ((s / 32) == dec_word) en_q[dec_ctx][s] <= req_wdata_i[s % 32];
        end
        RG_THR:  thr_q[dec_ctx] <= req_wdata_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // ---------------- response holding register ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_rdata_o <= req_write_i ? 32'd0 : rd_data;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  // ---------------- per-source gateways ----------------
  assign pend[0] = 1'b0;
  assign infl[0] = 1'b0;

  for (genvar g = 1; g <= NSRC; g++) begin : g_src
    irq_hub_gateway u_gw (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_i    (src_level_i[g]),
      .claim_i    (claim_vec[g]),
      .complete_i (cmpl_vec[g]),
      .pending_o  (pend[g]),
      .inflight_o (infl[g])
    );
  end

  // ---------------- per-context arbiters ----------------
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [NSRC:0] cand;
    assign cand = pend & en_q[c] & ~(NSRC+1)'(1);

    irq_hub_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand_i   (cand),
      .prio_i   (prio_q),
      .thr_i    (thr_q[c]),
      .win_id_o (win_id[c]),
      .req_o    (irq_o[c])
    );
  end

  // R11: a stalled response is held unchanged
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));

  // R11: every accepted request yields a response next cycle
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid_o);

  // R9: an out-of-range completion ID leaves flight state alone
  a_r9_bad_id_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cmpl && (req_wdata_i > 32'(NSRC))) |=> $stable(infl));

  // R7: at most one source changes to claimed per cycle
  a_r7_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));

endmodule

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
  localparam int NSRC = 31;
  localparam int NCTX = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC:1]     src_level = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [21:0]       req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [31:0]       rsp_rdata;
  logic [NCTX-1:0]   irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_hub #(.NSRC(NSRC), .NCTX(NCTX)) dut (
    .clk(clk), .rst_n(rst_n), .src_level_i(src_level),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per response transfer
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected response actual=%0h expected=none", rsp_rdata);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  // Driver: queue the expected response, then issue the request
  task automatic xfer(input bit w, input logic [21:0] a, input logic [31:0] d,
                      input logic [31:0] e, input string tag);
    bit acc;
    exp_q.push_back(w ? 32'd0 : e);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    xfer(1'b1, a, d, 32'd0, "R11 write response");
  endtask

  task automatic rd(input logic [21:0] a, input logic [31:0] e, input string tag);
    xfer(1'b0, a, 32'd0, e, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) begin @(posedge clk); #1; end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset state
    chk("R1 irq low after reset", 32'(irq), 32'd0);
    rd(22'h200004, 32'd0, "R1 claim ctx0 empty after reset");
    rd(22'h000014, 32'd0, "R1 priority zero after reset");
    rd(22'h002000, 32'd0, "R1 enable zero after reset");

    // R2 priority registers
    wr(22'h00000C, 32'hFF);
    rd(22'h00000C, 32'd7, "R2 priority masked to 3 bits");
    wr(22'h000000, 32'd5);
    rd(22'h000000, 32'd0, "R2 source 0 priority reads zero");
    wr(22'h000080, 32'd5);
    rd(22'h000080, 32'd0, "R10 priority beyond last source reads zero");

    // R3 enables
    wr(22'h002000, 32'hFFFF_FFFF);
    rd(22'h002000, 32'hFFFF_FFFE, "R3 enable word bit0 reads zero");
    rd(22'h002004, 32'd0, "R10 enable word 1 unmapped");
    rd(22'h002080, 32'd0, "R3 ctx1 enable separate");

    // R4 thresholds
    wr(22'h200000, 32'd9);
    rd(22'h200000, 32'd1, "R4 threshold masked to 3 bits");
    rd(22'h201000, 32'd0, "R4 ctx1 threshold separate");
    wr(22'h200000, 32'd0);

    // R5 request generation
    wr(22'h000014, 32'd2);  // src5
    wr(22'h000024, 32'd2);  // src9
    wr(22'h000030, 32'd0);  // src12
    drain();
    src_level[5] = 1'b1; src_level[9] = 1'b1; src_level[12] = 1'b1;
    cycles(2);
    chk("R5 ctx0 request with eligible sources", 32'(irq[0]), 32'd1);
    chk("R5 ctx1 quiet with nothing enabled", 32'(irq[1]), 32'd0);
    wr(22'h200000, 32'd2);
    drain();
    chk("R5 priority equal to threshold does not request", 32'(irq[0]), 32'd0);
    wr(22'h200000, 32'd1);
    drain();
    chk("R5 request back above threshold", 32'(irq[0]), 32'd1);

    // R6/R7 claims
    rd(22'h200004, 32'd5, "R6 tie goes to lowest ID");
    rd(22'h200004, 32'd9, "R7 claimed source removed, next wins");
    drain();
    chk("R5 priority-0 source never requests", 32'(irq[0]), 32'd0);
    rd(22'h200004, 32'd0, "R6 nothing eligible returns zero");

    // R7 cross-context mask
    wr(22'h002080, (32'd1 << 5) | (32'd1 << 9));
    rd(22'h201004, 32'd0, "R7 in-flight sources hidden from ctx1");

    // R9 bad completions
    wr(22'h200004, 32'd20);
    wr(22'h200004, 32'd41);  // would alias to 9 if truncated
    wr(22'h200004, 32'd0);

    // R8 completion reopens
    wr(22'h200004, 32'd5);
    drain();
    cycles(1);
    chk("R8 completed high line pends again", 32'(irq[1]), 32'd1);
    rd(22'h201004, 32'd5, "R8 reopened source claimable");
    rd(22'h201004, 32'd0, "R9 bad completions left source 9 held");

    src_level[9] = 1'b0;
    wr(22'h201004, 32'd9);
    drain();
    cycles(2);
    rd(22'h201004, 32'd0, "R8 completed low line stays idle");

    // R6 highest priority beats lower ID
    wr(22'h000010, 32'd1);  // src4
    wr(22'h000050, 32'd6);  // src20
    wr(22'h200000, 32'd0);
    drain();
    src_level[4] = 1'b1; src_level[20] = 1'b1;
    cycles(2);
    rd(22'h200004, 32'd20, "R6 higher priority wins");
    rd(22'h200004, 32'd4, "R6 lower priority next");
    rd(22'h200004, 32'd0, "R7 remaining sources held or ineligible");

    // R11 back-pressure
    drain();
    rsp_ready = 1'b0;
    rd(22'h00000C, 32'd7, "R11 stalled response delivered intact");
    cycles(3);
    @(negedge clk);
    chk("R11 response held valid", 32'(rsp_valid), 32'd1);
    chk("R11 request blocked while held", 32'(req_ready), 32'd0);
    chk("R11 held data stable", rsp_rdata, 32'd7);
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    drain();

    // R10 unmapped space
    wr(22'h100000, 32'hFFFF_FFFF);
    rd(22'h100000, 32'd0, "R10 unmapped gap reads zero");
    rd(22'h200008, 32'd0, "R10 context word +8 reads zero");
    rd(22'h202004, 32'd0, "R10 context beyond last reads zero");
    wr(22'h202000, 32'd7);
    rd(22'h200000, 32'd0, "R10 unmapped write left ctx0 threshold");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule